// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block keeps a small set of recent virtual-page to physical-frame translations. A requester presents a virtual page number and an access kind (read, write or execute). The number is compared against every stored translation at the same time. On a match the frame number and a permission verdict come back combinationally in the same cycle. The page offset never passes through the block, because virtual and physical pages have the same size.

When no entry matches, the block raises a walk request that carries the page number to an external page-table walker. The walker later returns the translation on the fill port. The block writes it into an entry chosen by a fixed rule. If the page number is already stored, that entry is overwritten. If not, the lowest-numbered empty entry is used. If every entry is full, a free-running linear feedback shift register picks the entry to replace. A flush input empties the whole buffer in one cycle.

Top module: `tlb_fa`

## Requirements
- R1: After a synchronous active-low reset no entry is valid, so every lookup misses.
- R2: A lookup whose page number matches a valid entry drives `lk_hit` high and `lk_pfn` to that entry's frame in the same cycle, with no clock edge in between. `lk_pfn` is zero whenever `lk_hit` is low.
- R3: Permission bits are bit 0 read, bit 1 write and bit 2 execute. `lk_acc` encodes 0 = read, 1 = write, 2 = execute and 3 = reserved, and the reserved code is never allowed. `lk_fault` is high exactly when a hit's access kind is not allowed by the entry, and it is never high on a miss.
- R4: `walk_req` is high exactly when `lk_valid` is high and no entry matches. `walk_vpn` carries `lk_vpn`.
- R5: A fill whose page number is not stored goes to the lowest-indexed invalid entry, if one exists.
- R6: When every entry is valid, a new fill replaces entry `rnd[IDX_W-1:0]`. `rnd` is an 8-bit register that is set to 1 while reset is asserted. On every other clock it shifts left, and the new bit 0 is the XOR of old bits 7, 5, 4 and 3. The fill uses the value held before the edge that writes it.
- R7: A fill whose page number already matches a valid entry overwrites that entry, so no page number is ever stored twice.
- R8: `flush` invalidates every entry at the next edge. A fill presented in the same cycle is discarded.
- R9: While `lk_valid` is low, `lk_hit`, `lk_fault` and `walk_req` stay low, even if `lk_vpn` matches an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup present |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| lk_hit | output | 1 | Translation found |
| lk_pfn | output | PFN_W | Physical frame number of the hit, zero otherwise |
| lk_fault | output | 1 | Hit whose access kind is not permitted |
| walk_req | output | 1 | Miss; translation needed from the walker |
| walk_vpn | output | VPN_W | Page number for the walker |
| fill_valid | input | 1 | Walker returns a translation |
| fill_vpn | input | VPN_W | Page number of the returned translation |
| fill_pfn | input | PFN_W | Frame number of the returned translation |
| fill_perm | input | 3 | Permission bits: bit 0 read, bit 1 write, bit 2 execute |
| flush | input | 1 | Invalidate all entries |

## Verification
A behavioural model built from queues and integers predicts every output on every cycle. The stimulus runs in phases, and each phase separates one rule from its neighbours. Filling a few pages into an empty buffer and then probing them with all four access kinds shows whether the permission bits are decoded per access kind rather than all together. Refilling a page that is already stored, and then filling exactly enough new pages to use every entry, reveals any duplicate copy: a duplicate would leave too few entries and force an early eviction. A long run of fills past capacity, each followed by a sweep over every page used so far, checks that the victim follows the shift-register sequence and not some other order. A flush issued together with a fill, and lookups with the valid input low, confirm that nothing leaks through.

// File: rtl/tlb_pkg.sv
// Package: shared types for the translation buffer.
// Assumes: permission field is three bits, access code is two bits.
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } tlb_acc_e;

    typedef struct packed {
        logic ex;
        logic wr;
        logic rd;
    } tlb_perm_t;

endpackage

// File: rtl/tlb_lfsr.sv
// Module: free-running Fibonacci shift register used as a replacement index source.
// Assumes: TAPS gives a maximal-length polynomial, SEED is non-zero, OUT_W <= W.
module tlb_lfsr #(
    parameter int W = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'h01,
    parameter int OUT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);

    logic [W-1:0] st_q;

    // Purpose: load seed on reset, otherwise shift in the tap parity every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SEED;
        else        st_q <= {st_q[W-2:0], ^(st_q & TAPS)};
    end

    assign rnd = st_q[OUT_W-1:0];

endmodule

// File: rtl/tlb_cam.sv
// Module: parallel tag compare against every entry.
// Assumes: tags packed entry 0 in the lowest bits.
module tlb_cam #(
    parameter int N = 8,
    parameter int W = 20
) (
    input  logic [N-1:0]   valid_vec,
    input  logic [N*W-1:0] tag_flat,
    input  logic [W-1:0]   key,
    output logic [N-1:0]   match
);

    // Purpose: one comparator per entry, qualified by its valid bit.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = valid_vec[i] && (tag_flat[i*W +: W] == key);
    end

endmodule

// File: rtl/tlb_victim.sv
// Module: picks the entry a fill writes: a matching entry first, then the
// lowest empty entry, then the random index.
// Assumes: dup has at most one bit set.
module tlb_victim #(
    parameter int N = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     valid_vec,
    input  logic [N-1:0]     dup,
    input  logic [IDX_W-1:0] rnd,
    output logic [IDX_W-1:0] idx
);

    // Purpose: priority select of the fill slot.
    always_comb begin
        idx = rnd;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) idx = IDX_W'(i);
        end
        for (int i = 0; i < N; i++) begin
            if (dup[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_fa.sv
// Module: fully associative translation buffer with permission check,
// walker request on miss, fill with random replacement, and flush.
// Assumes: ENTRIES is a power of two, at least 2, and not above 2**LFSR_W.
module tlb_fa #(
    parameter int VPN_W = 20,
    parameter int PFN_W = 16,
    parameter int ENTRIES = 8,
    parameter int LFSR_W = 8,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [1:0]       lk_acc,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    output logic             lk_fault,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic [2:0]       fill_perm,
    input  logic             flush
);
    import tlb_pkg::*;

    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0]       valid_q;
    logic [VPN_W-1:0]         tag_q  [ENTRIES];
    logic [PFN_W-1:0]         pfn_q  [ENTRIES];
    tlb_perm_t                perm_q [ENTRIES];
    logic [ENTRIES*VPN_W-1:0] tag_flat;
    logic [ENTRIES-1:0]       hit_vec;
    logic [ENTRIES-1:0]       dup_vec;
    logic [IDX_W-1:0]         rnd_idx;
    logic [IDX_W-1:0]         fill_idx;
    logic [PFN_W-1:0]         pfn_sel;
    tlb_perm_t                perm_sel;
    logic                     allow;
    logic                     any_match;
    logic                     fill_go;

    // Purpose: flatten stored tags for the comparators.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) tag_flat[i*VPN_W +: VPN_W] = tag_q[i];
    end

    tlb_cam #(.N(ENTRIES), .W(VPN_W)) u_look (
        .valid_vec(valid_q), .tag_flat(tag_flat), .key(lk_vpn), .match(hit_vec)
    );

    tlb_cam #(.N(ENTRIES), .W(VPN_W)) u_dup (
        .valid_vec(valid_q), .tag_flat(tag_flat), .key(fill_vpn), .match(dup_vec)
    );

    tlb_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED), .OUT_W(IDX_W)) u_rnd (
        .clk(clk), .rst_n(rst_n), .rnd(rnd_idx)
    );

    tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_vict (
        .valid_vec(valid_q), .dup(dup_vec), .rnd(rnd_idx), .idx(fill_idx)
    );

    // Purpose: OR-mux the frame and permissions of the (single) matching entry.
    always_comb begin
        pfn_sel  = '0;
        perm_sel = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                pfn_sel  = pfn_sel | pfn_q[i];
                perm_sel = perm_sel | perm_q[i];
            end
        end
    end

    // Purpose: decode whether the requested access kind is permitted.
    always_comb begin
        case (tlb_acc_e'(lk_acc))
            ACC_RD:  allow = perm_sel.rd;
            ACC_WR:  allow = perm_sel.wr;
            ACC_EX:  allow = perm_sel.ex;
            default: allow = 1'b0;
        endcase
    end

    assign any_match = |hit_vec;
    assign lk_hit    = lk_valid && any_match;
    assign lk_pfn    = lk_hit ? pfn_sel : '0;
    assign lk_fault  = lk_hit && !allow;
    assign walk_req  = lk_valid && !any_match;
    assign walk_vpn  = lk_vpn;
    assign fill_go   = fill_valid && !flush;

    // Purpose: valid bits: cleared by reset or flush, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n)       valid_q <= '0;
        else if (flush)   valid_q <= '0;
        else if (fill_go) valid_q[fill_idx] <= 1'b1;
    end

    // Purpose: write the translation payload into the chosen entry.
    always_ff @(posedge clk) begin
        if (rst_n && fill_go) begin
            tag_q[fill_idx]  <= fill_vpn;
            pfn_q[fill_idx]  <= fill_pfn;
            perm_q[fill_idx] <= tlb_perm_t'(fill_perm);
        end
    end

endmodule

// File: rtl/tlb_fa_chk.sv
// Module: property checker bound onto tlb_fa.
// Assumes: observes ports plus the valid and lookup-match vectors.
module tlb_fa_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         lk_valid,
    input logic         lk_hit,
    input logic         lk_fault,
    input logic         walk_req,
    input logic         flush,
    input logic         fill_valid,
    input logic [N-1:0] valid_vec,
    input logic [N-1:0] match_vec
);

    AST_FAULT_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit); // R3
    AST_WALK_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> (lk_valid && !lk_hit)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !walk_req && !lk_fault)); // R9
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0)); // R8
    AST_NO_DUP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec)); // R7
    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush) |=> (valid_vec != '0)); // R5

endmodule

bind tlb_fa tlb_fa_chk #(.N(ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit),
    .lk_fault(lk_fault), .walk_req(walk_req), .flush(flush),
    .fill_valid(fill_valid), .valid_vec(valid_q), .match_vec(hit_vec)
);

// File: tb/tlb_fa_bench.sv
// Bench: behavioural reference model compared on every clock.
module tlb_fa_bench;

    localparam int VW = 20;
    localparam int PW = 16;
    localparam int NE = 8;
    localparam int NV = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic [1:0]    lk_acc = '0;
    logic          lk_hit, lk_fault, walk_req;
    logic [PW-1:0] lk_pfn;
    logic [VW-1:0] walk_vpn;
    logic          fill_valid = 1'b0;
    logic [VW-1:0] fill_vpn = '0;
    logic [PW-1:0] fill_pfn = '0;
    logic [2:0]    fill_perm = '0;
    logic          flush = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    bit m_vld [NE];
    int m_tag [NE];
    int m_pfn [NE];
    int m_perm [NE];
    int m_rnd = 1;
    int used_q [$];

    always #5 clk = ~clk;

    tlb_fa u_tlb_fa (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .lk_acc(lk_acc), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_fault(lk_fault),
        .walk_req(walk_req), .walk_vpn(walk_vpn), .fill_valid(fill_valid),
        .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_perm(fill_perm),
        .flush(flush)
    );

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // one clock: drive, compare outputs against the model, advance the model
    task automatic step(string ph, bit rs, bit lv, int vpn, int acc,
                        bit fv, int fvpn, int fpfn, int fperm, bit fl);
        int e_hit, e_pfn, e_fault, slot;
        @(negedge clk);
        rst_n = rs; lk_valid = lv; lk_vpn = VW'(vpn); lk_acc = 2'(acc);
        fill_valid = fv; fill_vpn = VW'(fvpn); fill_pfn = PW'(fpfn);
        fill_perm = 3'(fperm); flush = fl;
        #2;
        e_hit = 0; e_pfn = 0; e_fault = 0;
        for (int i = 0; i < NE; i++)
            if (lv && m_vld[i] && m_tag[i] == vpn) begin
                e_hit = 1; e_pfn = m_pfn[i];
                e_fault = (acc == 3) ? 1 : (((m_perm[i] >> acc) & 1) == 0);
            end
        if (rs) begin
            chk({"R2 ", ph}, "hit", int'(lk_hit), e_hit);
            chk({"R2 ", ph}, "pfn", int'(lk_pfn), e_pfn);
            chk({"R3 ", ph}, "fault", int'(lk_fault), e_fault);
            chk(lv ? {"R4 ", ph} : {"R9 ", ph}, "walk_req", int'(walk_req), (lv && !e_hit) ? 1 : 0);
            if (lv) chk({"R4 ", ph}, "walk_vpn", int'(walk_vpn), vpn);
        end
        // model update for the coming edge
        if (!rs) begin
            foreach (m_vld[i]) m_vld[i] = 0;
            m_rnd = 1;
        end else begin
            if (fl) begin
                foreach (m_vld[i]) m_vld[i] = 0;
            end else if (fv) begin
                slot = -1;
                for (int i = 0; i < NE; i++) if (m_vld[i] && m_tag[i] == fvpn) slot = i;
                if (slot < 0) for (int i = NE - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
                if (slot < 0) slot = m_rnd % NE;
                m_vld[slot] = 1; m_tag[slot] = fvpn; m_pfn[slot] = fpfn; m_perm[slot] = fperm;
            end
            m_rnd = ((m_rnd << 1) & 8'hFE) |
                    (((m_rnd >> 7) ^ (m_rnd >> 5) ^ (m_rnd >> 4) ^ (m_rnd >> 3)) & 1);
        end
    endtask

    task automatic look(string ph, int vpn, int acc);
        step(ph, 1, 1, vpn, acc, 0, 0, 0, 0, 0);
    endtask

    task automatic fill(string ph, int vpn, int pfn, int perm);
        step(ph, 1, 0, 0, 0, 1, vpn, pfn, perm, 0);
    endtask

    task automatic sweep(string ph);
        foreach (used_q[k]) look(ph, used_q[k], k % 4);
    endtask

    function automatic int vpn_of(int k);
        return 'h400 + k * 37;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset, then lookups see an empty buffer
        repeat (3) step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        look("R1", vpn_of(0), 0);
        look("R1", 0, 0);

        // R2 / R3: three pages with differing permissions, all access kinds
        fill("R2", vpn_of(0), 'h11, 3'b001);
        fill("R2", vpn_of(1), 'h22, 3'b010);
        fill("R3", vpn_of(2), 'h33, 3'b111);
        for (int k = 0; k < 3; k++) begin
            used_q.push_back(vpn_of(k));
            for (int a = 0; a < 4; a++) look("R3", vpn_of(k), a);
        end

        // R7: refill an existing page with new data
        fill("R7", vpn_of(1), 'h2A, 3'b100);
        look("R7", vpn_of(1), 2);
        look("R7", vpn_of(1), 1);

        // R5: fill exactly up to capacity; a duplicate would force an eviction
        for (int k = 3; k < NE; k++) begin
            fill("R5", vpn_of(k), 'h100 + k, k % 8);
            used_q.push_back(vpn_of(k));
        end
        sweep("R5");

        // R6: fills beyond capacity, each followed by a sweep
        for (int k = NE; k < NV; k++) begin
            fill("R6", vpn_of(k), 'h200 + k, (k * 3) % 8);
            used_q.push_back(vpn_of(k));
            sweep("R6");
            if (k % 3 == 0) look("R6", 'h7, 0);
        end

        // R8: flush together with a fill, then sweep
        step("R8", 1, 0, 0, 0, 1, vpn_of(5), 'h55, 7, 1);
        sweep("R8");
        fill("R8", vpn_of(5), 'h55, 7);
        look("R8", vpn_of(5), 0);

        // R9: matching page presented with valid low
        step("R9", 1, 0, vpn_of(5), 1, 0, 0, 0, 0, 0);
        step("R9", 1, 0, vpn_of(5), 3, 0, 0, 0, 0, 0);
        look("R9", vpn_of(5), 3);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule